// File: doc/BRIEF.md
# Microcode Patch Redirecting Fetch Unit

This block is the front end of a microcode sequencer. A microinstruction pointer walks through a 12-bit micro-address space. The low part of that space is a fixed, computed ROM. The top part, from 0xF00 upward, is a small loadable patch RAM. Each fetched word carries its own successor address, so a patched flow can hand control back to ROM.

A bank of breakpoint entries sits beside the pointer. Each entry holds a valid bit, a match address and a destination address. Every running cycle, the pointer is compared against all valid entries at once. On a hit, fetch is diverted to the destination, and the diversion costs exactly one empty cycle.

A load port fills the patch RAM and the breakpoint entries. It takes effect only when the privileged input is high and the sequencer is not stepping. A count of the valid entries is always visible on an output.

Top module: `ucode_patch_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) leaves uop_valid=0, redirect=0, patch_count=0 and the pointer at 0x000. It clears all entry valid bits and zeroes every patch RAM word.
- R2: Each run cycle without a hit, with the pointer p below 0xF00, emits one word on the next cycle: uop_valid=1, uop_addr=p and uop_data={~p[3:0], p}. The pointer then moves to p+1, except that 0xEFF is followed by 0x000.
- R3: A pointer p in 0xF00..0xF3B reads patch RAM word p-0xF00. Each word is {next[11:0], payload[15:0]}, with the payload emitted on uop_data and next becoming the pointer. Pointers 0xF3C..0xFFF read an all-zero word.
- R4: In a run cycle where the pointer equals the match address of a valid entry, the next cycle shows redirect=1 and uop_valid=0, and the pointer becomes that entry's destination. The word at the destination is emitted one cycle later.
- R5: When several valid entries match the pointer, the entry with the lowest index supplies the destination.
- R6: Matching applies only to pointers below 0xF00, and an entry whose valid bit is 0 never matches.
- R7: A load request (ld_en=1) with ld_priv=0 changes neither the entries nor the patch RAM.
- R8: A load request in a cycle with run=1 is discarded.
- R9: A patch RAM load (ld_to_match=0) with ld_idx of 60 or more is discarded, and so is an entry load (ld_to_match=1) with ld_idx of 4 or more.
- R10: A patch RAM load writes word ld_idx as {ld_addr_b, ld_payload}. An entry load writes entry ld_idx with valid=ld_entry_valid, match=ld_addr_a and dest=ld_addr_b. patch_count equals the number of valid entries from the cycle after the load edge.
- R11: start=1 loads the pointer with start_addr and gives a cycle with uop_valid=0 and redirect=0; start takes priority over run. A cycle with run=0 and start=0 holds the pointer and gives uop_valid=0 and redirect=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Step the sequencer this cycle |
| start | input | 1 | Load the pointer with start_addr |
| start_addr | input | 12 | Entry micro-address |
| ld_en | input | 1 | Load request |
| ld_priv | input | 1 | Privileged mode; loads need it high |
| ld_to_match | input | 1 | 1 = breakpoint entry, 0 = patch RAM word |
| ld_idx | input | 6 | Entry or word index |
| ld_addr_a | input | 12 | Match address for entry loads |
| ld_addr_b | input | 12 | Destination (entry) or next address (RAM word) |
| ld_payload | input | 16 | RAM word payload |
| ld_entry_valid | input | 1 | Valid bit for entry loads |
| uop_valid | output | 1 | A fetched word is presented |
| uop_addr | output | 12 | Micro-address of the presented word |
| uop_data | output | 16 | Payload of the presented word |
| redirect | output | 1 | This cycle is the bubble of a patch diversion |
| patch_count | output | 3 | Number of valid breakpoint entries |

## Verification
All outputs are registered. A word fetched at pointer p in a run cycle appears on uop_valid, uop_addr and uop_data one cycle after that edge. A breakpoint hit shows its bubble (redirect high) at the same spot, and the destination word follows one cycle later. patch_count reflects a load from the cycle after the edge that accepted it. The bench changes inputs on falling edges, advances its own address-space model at the rising edge, and compares every output at the next falling edge. Every expected value therefore lands in the cycle where the registered result is due.

// File: rtl/ucp_pkg.sv
package ucp_pkg;

    localparam int ADDR_W = 12;
    localparam int PAY_W  = ADDR_W + 4;

    typedef logic [ADDR_W-1:0] uaddr_t;

    localparam uaddr_t PATCH_BASE = 12'hF00;
    localparam uaddr_t ROM_TOP    = uaddr_t'(PATCH_BASE - 12'd1);

    typedef struct packed {
        uaddr_t            nxt;
        logic [PAY_W-1:0]  pay;
    } uword_t;

    typedef struct packed {
        logic   vld;
        uaddr_t match;
        uaddr_t dest;
    } bkpt_t;

    function automatic logic in_patch_space(uaddr_t a);
        return a >= PATCH_BASE;
    endfunction

    function automatic uword_t rom_word(uaddr_t a);
        uword_t w;
        w.pay = {~a[3:0], a};
        w.nxt = (a == ROM_TOP) ? '0 : uaddr_t'(a + 12'd1);
        return w;
    endfunction

endpackage

// File: rtl/ucp_rom.sv
module ucp_rom
    import ucp_pkg::*;
(
    input  uaddr_t addr,
    output uword_t word
);

    assign word = in_patch_space(addr) ? '0 : rom_word(addr);

endmodule

// File: rtl/ucp_patch_ram.sv
module ucp_patch_ram
    import ucp_pkg::*;
#(
    parameter int DEPTH = 60,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  uword_t           wr_word,
    input  uaddr_t           rd_addr,
    output uword_t           rd_word
);

    uword_t mem [DEPTH];
    uaddr_t off;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            mem[wr_idx] <= wr_word;
        end
    end

    assign off = rd_addr - PATCH_BASE;

    always_comb begin
        rd_word = '0;
        if (in_patch_space(rd_addr) && (int'(off) < DEPTH))
            rd_word = mem[off[IDX_W-1:0]];
    end

endmodule

// File: rtl/ucp_match_bank.sv
module ucp_match_bank
    import ucp_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 6,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  bkpt_t            wr_entry,
    input  uaddr_t           look_addr,
    output logic             hit,
    output uaddr_t           hit_dest,
    output logic [CNT_W-1:0] count
);

    bkpt_t          ent [N];
    logic [N-1:0]   hv;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < N)) begin
            ent[wr_idx] <= wr_entry;
        end
    end

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_cmp
            assign hv[gi] = ent[gi].vld && (ent[gi].match == look_addr)
                            && !in_patch_space(look_addr);
        end
    endgenerate

    always_comb begin
        hit      = 1'b0;
        hit_dest = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit      = 1'b1;
                hit_dest = ent[i].dest;
            end
        end
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) count = count + CNT_W'(ent[i].vld);
    end

    // R9: an entry index past the bank leaves the valid population untouched
    a_r9_entry_index_bound: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_idx) >= N)) |=> $stable(count));

endmodule

// File: rtl/ucode_patch_seq.sv
module ucode_patch_seq
    import ucp_pkg::*;
#(
    parameter int N_MATCH    = 4,
    parameter int SRAM_DEPTH = 60,
    localparam int IDX_W = $clog2((SRAM_DEPTH > N_MATCH) ? SRAM_DEPTH : N_MATCH),
    localparam int CNT_W = $clog2(N_MATCH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic [11:0]      start_addr,
    input  logic             ld_en,
    input  logic             ld_priv,
    input  logic             ld_to_match,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [11:0]      ld_addr_a,
    input  logic [11:0]      ld_addr_b,
    input  logic [15:0]      ld_payload,
    input  logic             ld_entry_valid,
    output logic             uop_valid,
    output logic [11:0]      uop_addr,
    output logic [15:0]      uop_data,
    output logic             redirect,
    output logic [CNT_W-1:0] patch_count
);

    uaddr_t uip;
    uword_t rom_out, ram_out, fetch_word;
    logic   hit;
    uaddr_t hit_dest;
    logic   accept;
    bkpt_t  new_entry;
    uword_t new_word;

    assign accept    = ld_en && ld_priv && !run;
    assign new_entry = '{vld: ld_entry_valid, match: ld_addr_a, dest: ld_addr_b};
    assign new_word  = '{nxt: ld_addr_b, pay: ld_payload};

    ucp_rom i_rom (
        .addr (uip),
        .word (rom_out)
    );

    ucp_patch_ram #(.DEPTH(SRAM_DEPTH), .IDX_W(IDX_W)) i_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept && !ld_to_match),
        .wr_idx  (ld_idx),
        .wr_word (new_word),
        .rd_addr (uip),
        .rd_word (ram_out)
    );

    ucp_match_bank #(.N(N_MATCH), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept && ld_to_match),
        .wr_idx    (ld_idx),
        .wr_entry  (new_entry),
        .look_addr (uip),
        .hit       (hit),
        .hit_dest  (hit_dest),
        .count     (patch_count)
    );

    assign fetch_word = in_patch_space(uip) ? ram_out : rom_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            uip       <= '0;
            uop_valid <= 1'b0;
            uop_addr  <= '0;
            uop_data  <= '0;
            redirect  <= 1'b0;
        end else if (start) begin
            uip       <= start_addr;
            uop_valid <= 1'b0;
            redirect  <= 1'b0;
        end else if (run) begin
            if (hit) begin
                uip       <= hit_dest;
                uop_valid <= 1'b0;
                redirect  <= 1'b1;
            end else begin
                uip       <= fetch_word.nxt;
                uop_valid <= 1'b1;
                uop_addr  <= uip;
                uop_data  <= fetch_word.pay;
                redirect  <= 1'b0;
            end
        end else begin
            uop_valid <= 1'b0;
            redirect  <= 1'b0;
        end
    end

    // R1: reset leaves outputs quiet and no entry valid
    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (!uop_valid && !redirect && patch_count == '0));

    // R4: a hit costs one bubble cycle flagged by redirect
    a_r4_hit_bubble: assert property (@(posedge clk) disable iff (rst)
        (run && !start && hit) |=> (redirect && !uop_valid));

    // R2: a plain run cycle presents the word at the old pointer
    a_r2_fetch_reports_pointer: assert property (@(posedge clk) disable iff (rst)
        (run && !start && !hit) |=> (uop_valid && uop_addr == $past(uip)));

    // R7: unprivileged requests never change the entry population
    a_r7_priv_gate: assert property (@(posedge clk) disable iff (rst)
        !ld_priv |=> $stable(patch_count));

    // R8: no load lands while the sequencer steps
    a_r8_run_blocks_load: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(patch_count));

    // R11: an idle cycle presents nothing
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> (!uop_valid && !redirect));

endmodule

// File: tb/test_ucode_patch_seq.sv
module test_ucode_patch_seq;

    logic        clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, run, start, ld_en, ld_priv, ld_to_match, ld_entry_valid;
    logic [11:0] start_addr, ld_addr_a, ld_addr_b;
    logic [5:0]  ld_idx;
    logic [15:0] ld_payload;
    logic        uop_valid, redirect;
    logic [11:0] uop_addr;
    logic [15:0] uop_data;
    logic [2:0]  patch_count;

    ucode_patch_seq i_ucode_patch_seq (
        .clk(clk), .rst(rst), .run(run), .start(start), .start_addr(start_addr),
        .ld_en(ld_en), .ld_priv(ld_priv), .ld_to_match(ld_to_match), .ld_idx(ld_idx),
        .ld_addr_a(ld_addr_a), .ld_addr_b(ld_addr_b), .ld_payload(ld_payload),
        .ld_entry_valid(ld_entry_valid), .uop_valid(uop_valid), .uop_addr(uop_addr),
        .uop_data(uop_data), .redirect(redirect), .patch_count(patch_count)
    );

    // reference model state
    logic [11:0] m_uip;
    logic        m_vld   [4];
    logic [11:0] m_match [4];
    logic [11:0] m_dest  [4];
    logic [27:0] m_ram   [60];
    logic        e_valid, e_redir;
    logic [11:0] e_addr;
    logic [15:0] e_data;
    int          total = 0, bad = 0;

    function automatic logic [27:0] model_fetch(logic [11:0] a);
        logic [11:0] off;
        if (a >= 12'hF00) begin
            off = a - 12'hF00;
            if (off < 12'd60) return m_ram[off];
            return 28'h0;
        end
        return {(a == 12'hEFF) ? 12'h000 : a + 12'd1, ~a[3:0], a};
    endfunction

    function automatic int model_count();
        int c = 0;
        for (int i = 0; i < 4; i++) c += int'(m_vld[i]);
        return c;
    endfunction

    task automatic check(logic ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        string ftag, ctag;
        int    hidx = -1, nhits = 0;
        logic  sram_shadow = 1'b0;
        logic [27:0] w;
        if (m_uip < 12'hF00) begin
            for (int i = 0; i < 4; i++)
                if (m_vld[i] && m_match[i] == m_uip) begin
                    nhits++;
                    if (hidx < 0) hidx = i;
                end
        end else begin
            for (int i = 0; i < 4; i++)
                if (m_vld[i] && m_match[i] == m_uip) sram_shadow = 1'b1;
        end
        @(posedge clk);
        if (rst) begin
            m_uip = 12'h0; e_valid = 0; e_redir = 0;
            for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_match[i] = 0; m_dest[i] = 0; end
            for (int i = 0; i < 60; i++) m_ram[i] = 28'h0;
            ftag = "R1"; ctag = "R1";
        end else begin
            ctag = "R10";
            if (ld_en && !ld_priv) ctag = "R7";
            else if (ld_en && run) ctag = "R8";
            else if (ld_en && ((ld_to_match && ld_idx >= 6'd4) || (!ld_to_match && ld_idx >= 6'd60)))
                ctag = "R9";
            if (ld_en && ld_priv && !run) begin
                if (ld_to_match && ld_idx < 6'd4) begin
                    m_vld[ld_idx] = ld_entry_valid;
                    m_match[ld_idx] = ld_addr_a;
                    m_dest[ld_idx] = ld_addr_b;
                end else if (!ld_to_match && ld_idx < 6'd60) begin
                    m_ram[ld_idx] = {ld_addr_b, ld_payload};
                end
            end
            if (start) begin
                m_uip = start_addr; e_valid = 0; e_redir = 0; ftag = "R11";
            end else if (run) begin
                if (hidx >= 0) begin
                    m_uip = m_dest[hidx]; e_valid = 0; e_redir = 1;
                    ftag = (nhits > 1) ? "R5" : "R4";
                end else begin
                    w = model_fetch(m_uip);
                    e_valid = 1; e_redir = 0; e_addr = m_uip; e_data = w[15:0];
                    ftag = sram_shadow ? "R6" : ((m_uip >= 12'hF00) ? "R3" : "R2");
                    m_uip = w[27:16];
                end
            end else begin
                e_valid = 0; e_redir = 0; ftag = "R11";
            end
        end
        @(negedge clk);
        check(uop_valid === e_valid, ftag, "uop_valid", 32'(uop_valid), 32'(e_valid));
        check(redirect === e_redir, ftag, "redirect", 32'(redirect), 32'(e_redir));
        if (e_valid) begin
            check(uop_addr === e_addr, ftag, "uop_addr", 32'(uop_addr), 32'(e_addr));
            check(uop_data === e_data, ftag, "uop_data", 32'(uop_data), 32'(e_data));
        end
        check(int'(patch_count) == model_count(), ctag, "patch_count",
              32'(patch_count), 32'(model_count()));
    endtask

    task automatic idle_inputs();
        run = 0; start = 0; ld_en = 0; ld_priv = 0; ld_to_match = 0;
        ld_entry_valid = 0; ld_idx = 0; ld_addr_a = 0; ld_addr_b = 0; ld_payload = 0;
        start_addr = 0;
    endtask

    task automatic start_at(logic [11:0] a);
        idle_inputs(); start = 1; start_addr = a; step(); idle_inputs();
    endtask

    task automatic run_n(int n);
        idle_inputs(); run = 1;
        for (int i = 0; i < n; i++) step();
        idle_inputs();
    endtask

    task automatic load(logic to_m, logic [5:0] idx, logic [11:0] a, logic [11:0] b,
                        logic [15:0] pay, logic v, logic priv, logic with_run);
        idle_inputs();
        ld_en = 1; ld_to_match = to_m; ld_idx = idx; ld_addr_a = a; ld_addr_b = b;
        ld_payload = pay; ld_entry_valid = v; ld_priv = priv; run = with_run;
        step(); idle_inputs();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired R2 actual hung expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        m_uip = 0; e_valid = 0; e_redir = 0; e_addr = 0; e_data = 0;
        for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_match[i] = 0; m_dest[i] = 0; end
        for (int i = 0; i < 60; i++) m_ram[i] = 0;
        idle_inputs(); rst = 1;
        @(negedge clk);
        step(); step();                                   // R1
        rst = 0;
        start_at(12'h010); run_n(5);                      // R2 sequential ROM
        start_at(12'hEFE); run_n(3);                      // R2 wrap at top of ROM
        load(1, 6'd0, 12'h020, 12'hF00, 16'h0, 1, 0, 0);  // R7 unprivileged
        load(1, 6'd0, 12'h020, 12'hF00, 16'h0, 1, 1, 1);  // R8 while running
        load(0, 6'd0, 12'h0, 12'hF01, 16'hBEEF, 0, 1, 0); // R10 RAM words
        load(0, 6'd1, 12'h0, 12'h025, 16'h1234, 0, 1, 0);
        load(1, 6'd0, 12'h020, 12'hF00, 16'h0, 1, 1, 0);
        start_at(12'h01E); run_n(8);                      // R4 divert and return, R3
        load(1, 6'd1, 12'h020, 12'hF10, 16'h0, 1, 1, 0);
        start_at(12'h01E); run_n(5);                      // R5 lowest index wins
        load(1, 6'd0, 12'h020, 12'hF00, 16'h0, 0, 1, 0);
        start_at(12'h01E); run_n(5);                      // R6 invalid entry skipped
        load(1, 6'd2, 12'hF01, 12'h030, 16'h0, 1, 1, 0);
        start_at(12'hF00); run_n(4);                      // R6 no match in patch space
        load(0, 6'd60, 12'h0, 12'h123, 16'hAAAA, 0, 1, 0); // R9 RAM bound
        load(1, 6'd5, 12'h011, 12'h000, 16'h0, 1, 1, 0);  // R9 entry bound
        start_at(12'hF3C); run_n(2);                      // R3 unpopulated reads zero
        start_at(12'h011); run_n(2);                      // R9 entry 5 absent: no hit
        step();                                           // R11 idle
        for (int k = 0; k < 4000; k++) begin
            idle_inputs();
            rst   = ($urandom % 200) == 0;
            run   = ($urandom % 10) < 6;
            start = ($urandom % 10) == 0;
            start_addr = ($urandom % 2) ? 12'($urandom % 64) : 12'(12'hF00 + $urandom % 70);
            ld_en = ($urandom % 10) < 3;
            ld_priv = ($urandom % 10) < 7;
            ld_to_match = $urandom % 2;
            ld_idx = 6'($urandom);
            ld_addr_a = 12'($urandom % 64);
            ld_addr_b = ($urandom % 2) ? 12'($urandom % 64) : 12'(12'hF00 + $urandom % 64);
            ld_payload = 16'($urandom);
            ld_entry_valid = ($urandom % 4) != 0;
            step();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule